// File: doc/BRIEF.md
# Line-Fill Miss Tracker

This block tracks outstanding instruction-line misses between a cache and the next memory level. It has two separate pools of tracking entries, one for demand fetches and one for prefetches. Each entry holds a line address. It sends exactly one acquire on a simple request channel. It then waits for a single-beat grant that carries the whole line and a corrupt flag. A grant is matched to its entry by a one-hot source tag. The line is captured into one line register that all entries share. In the next cycle that register drives a response to the requesters and, when allowed, a write towards the cache arrays.

A flush affects each entry according to how far it has progressed. An entry that has not gone out on the bus is dropped at once. An entry that has already gone out stays occupied until its grant returns, and that grant is then swallowed. A grant that arrives in the same cycle as a flush is still returned to the requesters, but it is not written to the arrays. A corrupt grant is returned as an access fault. A new request for a line that is already outstanding shares the existing entry instead of taking a second one.

Top module: `line_fill_mshr`

## Requirements
- R1: After reset no acquire is offered, no response or array write is driven, and both request-ready outputs are high.
- R2: Source bit i of an acquire tags entry i. Fetch entries use bits 0 to NUM_FETCH-1 and prefetch entries use the bits above them. Among entries that have not issued, the lowest index goes to the bus first, so fetch entries go before prefetch entries.
- R3: A request whose line address equals that of a live, unflushed entry is accepted without taking a new entry. A fetch and a prefetch for the same line in one cycle take only one entry. Neither case produces a second acquire.
- R4: One cycle after a grant for a live entry, the response and the array write are both valid, carrying the entry's line address and the granted data, and the entry becomes free.
- R5: A grant flagged corrupt gives a response with the fault bit set and no array write.
- R6: A flush drops every entry that has not issued its acquire, so that line never reaches the bus. No acquire is offered while flush is high.
- R7: An entry that has issued and is then flushed keeps its slot until its grant arrives. That grant produces neither a response nor an array write.
- R8: A grant that arrives in the same cycle as a flush still produces a response with its data, but no array write.
- R9: Both request-ready outputs are low in any cycle in which flush is high.
- R10: When all entries of a pool are occupied, that pool's ready is low for a line that has no entry, and stays high for a line that already has one. The other pool is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Flush request |
| fetch_req_valid | input | 1 | Demand miss request |
| fetch_req_addr | input | ADDR_W | Demand miss line address |
| fetch_req_ready | output | 1 | Demand request accepted |
| pf_req_valid | input | 1 | Prefetch miss request |
| pf_req_addr | input | ADDR_W | Prefetch line address |
| pf_req_ready | output | 1 | Prefetch request accepted |
| acq_valid | output | 1 | Bus acquire valid |
| acq_ready | input | 1 | Bus acquire accepted |
| acq_addr | output | ADDR_W | Acquire line address |
| acq_src | output | NUM_FETCH+NUM_PREF | One-hot acquire source tag |
| gnt_valid | input | 1 | Grant valid (single beat) |
| gnt_src | input | NUM_FETCH+NUM_PREF | One-hot grant source tag |
| gnt_data | input | LINE_W | Granted line |
| gnt_corrupt | input | 1 | Grant corrupt/denied flag |
| rsp_valid | output | 1 | Line returned to requesters |
| rsp_addr | output | ADDR_W | Returned line address |
| rsp_data | output | LINE_W | Returned line data |
| rsp_fault | output | 1 | Returned line is an access fault |
| wr_valid | output | 1 | Cache array write |
| wr_addr | output | ADDR_W | Array write line address |
| wr_data | output | LINE_W | Array write data |

## Verification
A wrong issued or flushed bit shows up at the bus. The acquire appears or disappears in the cycle right after the flush. The problem also shows when the entry's grant comes back, because the response and write strobes one cycle later are either missing or unexpectedly present. A stale valid bit in a slot moves the source tag of the next allocation and pulls request-ready low early. Both show at the ports in the cycle after the stimulus. A broken address compare either produces a second acquire for a merged line or drops a needed one. That is visible as soon as the bus is released.

// File: rtl/line_fill_mshr_pkg.sv
package line_fill_mshr_pkg;

  // Decision taken in the grant cycle, consumed by the shared line stage
  typedef struct packed {
    logic take;   // capture the line and return it
    logic write;  // also write it to the arrays
    logic fault;  // grant was corrupt
  } fill_ctl_t;

endpackage

// File: rtl/mshr_first_one.sv
module mshr_first_one #(
  parameter int N = 4
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] sel_o,
  output logic         any_o
);

  logic found;

  always_comb begin
    sel_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        sel_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/mshr_slot.sv
module mshr_slot #(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              issue_i,
  input  logic              grant_i,
  input  logic              flush_i,
  output logic              valid_o,
  output logic              issued_o,
  output logic              flushed_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              valid_q, valid_d;
  logic              issued_q, issued_d;
  logic              flushed_q, flushed_d;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    valid_d   = valid_q;
    issued_d  = issued_q;
    flushed_d = flushed_q;
    if (grant_i) begin
      valid_d   = 1'b0;
      issued_d  = 1'b0;
      flushed_d = 1'b0;
    end else if (alloc_i) begin
      valid_d   = 1'b1;
      issued_d  = 1'b0;
      flushed_d = 1'b0;
    end else begin
      if (issue_i) issued_d = 1'b1;
      if (flush_i && valid_q) begin
        if (issued_q) begin
          flushed_d = 1'b1;
        end else begin
          valid_d  = 1'b0;
          issued_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      issued_q  <= 1'b0;
      flushed_q <= 1'b0;
    end else begin
      valid_q   <= valid_d;
      issued_q  <= issued_d;
      flushed_q <= flushed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (alloc_i) begin
      addr_q <= addr_i;
    end
  end

  assign valid_o   = valid_q;
  assign issued_o  = issued_q;
  assign flushed_o = flushed_q;
  assign addr_o    = addr_q;

  assert_flush_drops_unsent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && valid_q && !issued_q) |=> !valid_q);

  assert_flush_keeps_sent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && valid_q && issued_q && !grant_i) |=> (valid_q && flushed_q));

  assert_mark_needs_issue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flushed_q |-> (valid_q && issued_q));

endmodule

// File: rtl/mshr_fill_stage.sv
module mshr_fill_stage
  import line_fill_mshr_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  fill_ctl_t         ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LINE_W-1:0] data_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [LINE_W-1:0] rsp_data_o,
  output logic              rsp_fault_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LINE_W-1:0] wr_data_o
);

  logic              take_q, write_q, fault_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LINE_W-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q  <= 1'b0;
      write_q <= 1'b0;
    end else begin
      take_q  <= ctl_i.take;
      write_q <= ctl_i.take && ctl_i.write;
    end
  end

  // one line register shared by every entry; loaded only when a line is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      addr_q  <= '0;
      line_q  <= '0;
    end else if (ctl_i.take) begin
      fault_q <= ctl_i.fault;
      addr_q  <= addr_i;
      line_q  <= data_i;
    end
  end

  assign rsp_valid_o = take_q;
  assign rsp_addr_o  = addr_q;
  assign rsp_data_o  = line_q;
  assign rsp_fault_o = fault_q;
  assign wr_valid_o  = write_q;
  assign wr_addr_o   = addr_q;
  assign wr_data_o   = line_q;

  assert_write_has_response_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (rsp_valid_o && !rsp_fault_o));

  assert_flush_blocks_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !wr_valid_o);

endmodule

// File: rtl/line_fill_mshr.sv
module line_fill_mshr
  import line_fill_mshr_pkg::*;
#(
  parameter int NUM_FETCH = 4,
  parameter int NUM_PREF  = 10,
  parameter int ADDR_W    = 26,
  parameter int LINE_W    = 512
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          fetch_req_valid,
  input  logic [ADDR_W-1:0]             fetch_req_addr,
  output logic                          fetch_req_ready,
  input  logic                          pf_req_valid,
  input  logic [ADDR_W-1:0]             pf_req_addr,
  output logic                          pf_req_ready,
  output logic                          acq_valid,
  input  logic                          acq_ready,
  output logic [ADDR_W-1:0]             acq_addr,
  output logic [NUM_FETCH+NUM_PREF-1:0] acq_src,
  input  logic                          gnt_valid,
  input  logic [NUM_FETCH+NUM_PREF-1:0] gnt_src,
  input  logic [LINE_W-1:0]             gnt_data,
  input  logic                          gnt_corrupt,
  output logic                          rsp_valid,
  output logic [ADDR_W-1:0]             rsp_addr,
  output logic [LINE_W-1:0]             rsp_data,
  output logic                          rsp_fault,
  output logic                          wr_valid,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [LINE_W-1:0]             wr_data
);

  localparam int NE = NUM_FETCH + NUM_PREF;

  logic [NE-1:0]     ent_valid, ent_issued, ent_flushed;
  logic [ADDR_W-1:0] ent_addr [NE];
  logic [NE-1:0]     grant_hit, issue_hit, alloc_vec;
  logic [NE-1:0]     match_f, match_p;

  logic [NUM_FETCH-1:0] f_free_sel;
  logic [NUM_PREF-1:0]  p_free_sel;
  logic                 f_any_free, p_any_free;
  logic                 f_hit, p_hit, f_fire, p_fire;

  logic [NE-1:0] pend_sel;
  logic          pend_any;

  fill_ctl_t         fill_ctl;
  logic [ADDR_W-1:0] gnt_addr;

  assign grant_hit = gnt_valid ? gnt_src : '0;

  // merge lookup: only live, unflushed entries that are not retiring now
  always_comb begin
    for (int i = 0; i < NE; i++) begin
      match_f[i] = ent_valid[i] && !ent_flushed[i] && !grant_hit[i]
                   && (ent_addr[i] == fetch_req_addr);
      match_p[i] = ent_valid[i] && !ent_flushed[i] && !grant_hit[i]
                   && (ent_addr[i] == pf_req_addr);
    end
  end

  mshr_first_one #(.N(NUM_FETCH)) i_free_fetch (
    .req_i (~ent_valid[NUM_FETCH-1:0]),
    .sel_o (f_free_sel),
    .any_o (f_any_free)
  );

  mshr_first_one #(.N(NUM_PREF)) i_free_pref (
    .req_i (~ent_valid[NE-1:NUM_FETCH]),
    .sel_o (p_free_sel),
    .any_o (p_any_free)
  );

  assign f_hit           = |match_f;
  assign fetch_req_ready = !flush && (f_hit || f_any_free);
  assign f_fire          = fetch_req_valid && fetch_req_ready;

  assign p_hit           = (|match_p) || (f_fire && (fetch_req_addr == pf_req_addr));
  assign pf_req_ready    = !flush && (p_hit || p_any_free);
  assign p_fire          = pf_req_valid && pf_req_ready;

  assign alloc_vec = { (p_fire && !p_hit) ? p_free_sel : '0,
                       (f_fire && !f_hit) ? f_free_sel : '0 };

  // issue order: lowest index first, fetch pool sits at the low end
  mshr_first_one #(.N(NE)) i_issue_pick (
    .req_i (ent_valid & ~ent_issued),
    .sel_o (pend_sel),
    .any_o (pend_any)
  );

  assign acq_valid = pend_any && !flush;
  assign acq_src   = pend_sel;
  assign issue_hit = (acq_valid && acq_ready) ? pend_sel : '0;

  always_comb begin
    acq_addr = '0;
    gnt_addr = '0;
    for (int i = 0; i < NE; i++) begin
      if (pend_sel[i]) acq_addr = acq_addr | ent_addr[i];
      if (gnt_src[i])  gnt_addr = gnt_addr | ent_addr[i];
    end
  end

  generate
    for (genvar g = 0; g < NE; g++) begin : g_slot
      mshr_slot #(.ADDR_W(ADDR_W)) i_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_i   (alloc_vec[g]),
        .addr_i    ((g < NUM_FETCH) ? fetch_req_addr : pf_req_addr),
        .issue_i   (issue_hit[g]),
        .grant_i   (grant_hit[g]),
        .flush_i   (flush),
        .valid_o   (ent_valid[g]),
        .issued_o  (ent_issued[g]),
        .flushed_o (ent_flushed[g]),
        .addr_o    (ent_addr[g])
      );
    end
  endgenerate

  always_comb begin
    fill_ctl.take  = |(grant_hit & ent_valid & ent_issued & ~ent_flushed);
    fill_ctl.write = !flush && !gnt_corrupt;
    fill_ctl.fault = gnt_corrupt;
  end

  mshr_fill_stage #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) i_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush),
    .ctl_i       (fill_ctl),
    .addr_i      (gnt_addr),
    .data_i      (gnt_data),
    .rsp_valid_o (rsp_valid),
    .rsp_addr_o  (rsp_addr),
    .rsp_data_o  (rsp_data),
    .rsp_fault_o (rsp_fault),
    .wr_valid_o  (wr_valid),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data)
  );

  assert_acq_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acq_valid |-> ($countones(acq_src) == 1));

  assert_no_issue_in_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !acq_valid);

  assert_ready_low_in_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !(fetch_req_ready || pf_req_ready));

  assert_grant_source_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> $onehot0(gnt_src));

endmodule

// File: tb/test_line_fill_mshr.sv
`timescale 1ns/1ps
module test_line_fill_mshr;

  localparam int NF = 4;
  localparam int NP = 10;
  localparam int NE = NF + NP;
  localparam int AW = 26;
  localparam int LW = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic          fetch_req_valid = 1'b0;
  logic [AW-1:0] fetch_req_addr = '0;
  logic          fetch_req_ready;
  logic          pf_req_valid = 1'b0;
  logic [AW-1:0] pf_req_addr = '0;
  logic          pf_req_ready;
  logic          acq_valid;
  logic          acq_ready = 1'b0;
  logic [AW-1:0] acq_addr;
  logic [NE-1:0] acq_src;
  logic          gnt_valid = 1'b0;
  logic [NE-1:0] gnt_src = '0;
  logic [LW-1:0] gnt_data = '0;
  logic          gnt_corrupt = 1'b0;
  logic          rsp_valid;
  logic [AW-1:0] rsp_addr;
  logic [LW-1:0] rsp_data;
  logic          rsp_fault;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [LW-1:0] wr_data;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  line_fill_mshr #(.NUM_FETCH(NF), .NUM_PREF(NP), .ADDR_W(AW), .LINE_W(LW)) i_line_fill_mshr (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .fetch_req_valid(fetch_req_valid), .fetch_req_addr(fetch_req_addr), .fetch_req_ready(fetch_req_ready),
    .pf_req_valid(pf_req_valid), .pf_req_addr(pf_req_addr), .pf_req_ready(pf_req_ready),
    .acq_valid(acq_valid), .acq_ready(acq_ready), .acq_addr(acq_addr), .acq_src(acq_src),
    .gnt_valid(gnt_valid), .gnt_src(gnt_src), .gnt_data(gnt_data), .gnt_corrupt(gnt_corrupt),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data), .rsp_fault(rsp_fault),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] pat(input logic [AW-1:0] a);
    return {16{({6'b0, a} ^ 32'h5a5a_0000)}};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input bit f, input bit p, input logic [AW-1:0] fa, input logic [AW-1:0] pa);
    fetch_req_valid = f;
    fetch_req_addr  = fa;
    pf_req_valid    = p;
    pf_req_addr     = pa;
    tick();
    fetch_req_valid = 1'b0;
    pf_req_valid    = 1'b0;
  endtask

  task automatic issue_one(input logic [NE-1:0] exp_src, input logic [AW-1:0] exp_addr, input string req);
    check({req, " acq_valid"}, LW'(acq_valid), LW'(1'b1));
    check({req, " acq_src"}, LW'(acq_src), LW'(exp_src));
    check({req, " acq_addr"}, LW'(acq_addr), LW'(exp_addr));
    acq_ready = 1'b1;
    tick();
    acq_ready = 1'b0;
  endtask

  task automatic grant(input logic [NE-1:0] src, input logic [AW-1:0] a, input bit corrupt,
                       input bit with_flush, input bit exp_rsp, input bit exp_wr, input string req);
    gnt_valid   = 1'b1;
    gnt_src     = src;
    gnt_data    = pat(a);
    gnt_corrupt = corrupt;
    flush       = with_flush;
    tick();
    gnt_valid   = 1'b0;
    gnt_corrupt = 1'b0;
    flush       = 1'b0;
    check({req, " rsp_valid"}, LW'(rsp_valid), LW'(exp_rsp));
    check({req, " wr_valid"}, LW'(wr_valid), LW'(exp_wr));
    if (exp_rsp) begin
      check({req, " rsp_addr"}, LW'(rsp_addr), LW'(a));
      check({req, " rsp_data"}, rsp_data, pat(a));
      check({req, " rsp_fault"}, LW'(rsp_fault), LW'(corrupt));
    end
    if (exp_wr) begin
      check({req, " wr_addr"}, LW'(wr_addr), LW'(a));
      check({req, " wr_data"}, wr_data, pat(a));
    end
  endtask

  task automatic t_reset();
    check("R1 acq_valid", LW'(acq_valid), '0);
    check("R1 rsp_valid", LW'(rsp_valid), '0);
    check("R1 wr_valid", LW'(wr_valid), '0);
    check("R1 fetch ready", LW'(fetch_req_ready), LW'(1'b1));
    check("R1 pf ready", LW'(pf_req_ready), LW'(1'b1));
  endtask

  task automatic t_order();
    send(1'b0, 1'b1, '0, 26'h00a0);
    check("R2 prefetch tag", LW'(acq_src), LW'(NE'(1) << NF));
    send(1'b1, 1'b0, 26'h00b0, '0);
    issue_one(NE'(1), 26'h00b0, "R2 fetch first");
    issue_one(NE'(1) << NF, 26'h00a0, "R2 prefetch next");
    check("R2 nothing pending", LW'(acq_valid), '0);
    grant(NE'(1), 26'h00b0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 fetch line");
    grant(NE'(1) << NF, 26'h00a0, 1'b0, 1'b0, 1'b1, 1'b1, "R4 prefetch line");
    tick();
    check("R4 response one cycle", LW'(rsp_valid), '0);
  endtask

  task automatic t_merge();
    send(1'b1, 1'b0, 26'h00c0, '0);
    send(1'b0, 1'b1, '0, 26'h00c0);
    issue_one(NE'(1), 26'h00c0, "R3 merged");
    check("R3 no second acquire", LW'(acq_valid), '0);
    grant(NE'(1), 26'h00c0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 merged grant");
    send(1'b1, 1'b1, 26'h00d0, 26'h00d0);
    issue_one(NE'(1), 26'h00d0, "R3 same cycle");
    check("R3 same cycle single entry", LW'(acq_valid), '0);
    grant(NE'(1), 26'h00d0, 1'b0, 1'b0, 1'b1, 1'b1, "R3 same cycle grant");
  endtask

  task automatic t_corrupt();
    send(1'b1, 1'b0, 26'h00e0, '0);
    issue_one(NE'(1), 26'h00e0, "R5 issue");
    grant(NE'(1), 26'h00e0, 1'b1, 1'b0, 1'b1, 1'b0, "R5 corrupt");
  endtask

  task automatic t_flush_unsent();
    send(1'b1, 1'b0, 26'h00f0, '0);
    flush = 1'b1;
    #1;
    check("R6 no acquire in flush", LW'(acq_valid), '0);
    check("R9 fetch ready in flush", LW'(fetch_req_ready), '0);
    check("R9 pf ready in flush", LW'(pf_req_ready), '0);
    tick();
    flush = 1'b0;
    #1;
    check("R6 unsent entry dropped", LW'(acq_valid), '0);
    tick();
    check("R6 still nothing", LW'(acq_valid), '0);
  endtask

  task automatic t_flush_sent();
    send(1'b1, 1'b0, 26'h0100, '0);
    issue_one(NE'(1), 26'h0100, "R7 issue");
    flush = 1'b1;
    tick();
    flush = 1'b0;
    send(1'b1, 1'b0, 26'h0100, '0);
    issue_one(NE'(2), 26'h0100, "R7 flushed slot held");
    grant(NE'(1), 26'h0100, 1'b0, 1'b0, 1'b0, 1'b0, "R7 swallowed");
    grant(NE'(2), 26'h0100, 1'b0, 1'b0, 1'b1, 1'b1, "R7 new entry");
  endtask

  task automatic t_grant_with_flush();
    send(1'b1, 1'b0, 26'h0110, '0);
    issue_one(NE'(1), 26'h0110, "R8 issue");
    grant(NE'(1), 26'h0110, 1'b0, 1'b1, 1'b1, 1'b0, "R8 same cycle");
  endtask

  task automatic t_full();
    for (int k = 0; k < NF; k++) send(1'b1, 1'b0, AW'(12'h200 + k), '0);
    fetch_req_addr = 26'h0300;
    pf_req_addr    = 26'h0300;
    #1;
    check("R10 fetch pool full", LW'(fetch_req_ready), '0);
    check("R10 prefetch pool free", LW'(pf_req_ready), LW'(1'b1));
    fetch_req_addr = 26'h0202;
    #1;
    check("R10 full pool merge", LW'(fetch_req_ready), LW'(1'b1));
    flush = 1'b1;
    tick();
    flush = 1'b0;
    fetch_req_addr = 26'h0300;
    #1;
    check("R10 pool freed", LW'(fetch_req_ready), LW'(1'b1));
    check("R10 nothing pending", LW'(acq_valid), '0);
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_order();
    t_merge();
    t_corrupt();
    t_flush_unsent();
    t_flush_sent();
    t_grant_with_flush();
    t_full();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule